// File: doc/BRIEF.md
# Watermarked Channel Word FIFO

This block is the storage stage of one audio data channel: a ring of 32-bit words with a write port, a read port and two programmable fill thresholds. It serves both directions. In a capture channel a hardware source drives the write port and the bus drains the read port. In a playback channel the bus fills the write port and a hardware sink pulls from the read port. Which side is which is decided only by where the two ports are wired.

Software places both thresholds with one register write. It can empty the ring with a one-cycle clear request. It can read a status vector, a pointer readback word, and the fill and free counts in bytes. The level flags make short event pulses when they rise. A dropped write makes an overflow pulse. A controller uses these pulses to start a DMA burst or to raise an interrupt.

One slot of the ring stays unused, so that equal read and write addresses always mean "empty". The usable capacity is therefore DEPTH-1 words.

Top module: `wm_word_fifo`

## Requirements
- R1: After reset the block shows an empty ring: status is 4'b1010, the pointer word is 0, fill_bytes is 0, free_bytes is 2048, rd_data is 0, all pulses are low, and wm_q reads 32'h0000_01FF (almost-full threshold 511, almost-empty threshold 0).
- R2: Words come out of rd_data in the order they were written. The word appears in the cycle after the edge that sampled rd_en.
- R3: The ring holds 511 words, and status bit 0 (real full) is high exactly when it holds 511. A write while full is dropped and leaves the write address unchanged. It makes ovf_pulse high for the one cycle after that edge.
- R4: A read while the ring is empty sets rd_data to 0 and leaves both addresses unchanged.
- R5: ptr_word carries the write address in bits [9:0] and the read address in bits [25:16]. All other bits are 0.
- R6: fill_bytes is 4*(wr-rd) when wr>=rd and 4*(512-rd+wr) otherwise, where wr and rd are the addresses in ptr_word.
- R7: free_bytes is 4*(512-wr+rd) when wr>=rd and 4*(rd-wr) otherwise.
- R8: A write of wm_wdata with wm_we loads the almost-full threshold from bits [8:0] and the almost-empty threshold from bits [24:16]. wm_q returns the two thresholds in the same bit positions and 0 in every other bit.
- R9: Status bit 1 is real empty. Bit 2 (almost full) is high while the fill in words is at or above the almost-full threshold. Bit 3 (almost empty) is high while the fill is at or below the almost-empty threshold.
- R10: af_pulse and ae_pulse go high for exactly one cycle after their level flag changes from low to high.
- R11: clr returns both addresses to 0 at the next edge. A write or read requested in the same cycle is discarded and makes no overflow pulse.
- R12: With the almost-full threshold at 511, the almost-full flag is high only when the ring is real full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | One-cycle request to empty the ring |
| wr_en | input | 1 | Write one word |
| wr_data | input | 32 | Word to write |
| rd_en | input | 1 | Read one word |
| rd_data | output | 32 | Word read, registered |
| wm_we | input | 1 | Load the threshold register |
| wm_wdata | input | 32 | New threshold register value |
| wm_q | output | 32 | Threshold register readback |
| status | output | 4 | {almost empty, almost full, real empty, real full} |
| ptr_word | output | 32 | Read and write address readback |
| fill_bytes | output | 12 | Stored data in bytes |
| free_bytes | output | 12 | Free space in bytes |
| ae_pulse | output | 1 | Almost-empty rising event |
| af_pulse | output | 1 | Almost-full rising event |
| ovf_pulse | output | 1 | Write dropped while full |

## Verification
Every result is due one edge after its stimulus. status, ptr_word, fill_bytes, free_bytes and wm_q are decoded from registers, so they settle in the cycle after the edge that updated them. rd_data, ovf_pulse and the two level pulses come from registers loaded at that same edge. The bench therefore drives inputs 1 ns after a rising edge and samples outputs 1 ns after the next rising edge, so each check sees the cycle its requirement names. The pulse checks also sample one cycle later to confirm that each pulse has dropped.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  // threshold register field positions (decoded by software)
  localparam int unsigned WM_AF_LSB = 0;
  localparam int unsigned WM_AE_LSB = 16;
  // pointer readback field positions
  localparam int unsigned PW_WR_LSB = 0;
  localparam int unsigned PW_RD_LSB = 16;
  // status vector bit order
  localparam int unsigned ST_FULL   = 0;
  localparam int unsigned ST_EMPTY  = 1;
  localparam int unsigned ST_AFULL  = 2;
  localparam int unsigned ST_AEMPTY = 3;

  // stored data in bytes, from the two ring addresses
  function automatic int unsigned fill_bytes_f(input int unsigned wr,
                                               input int unsigned rd,
                                               input int unsigned depth);
    if (wr >= rd) return 4 * (wr - rd);
    return 4 * (depth - rd + wr);
  endfunction

  // free space in bytes, from the two ring addresses
  function automatic int unsigned free_bytes_f(input int unsigned wr,
                                               input int unsigned rd,
                                               input int unsigned depth);
    if (wr >= rd) return 4 * (depth - wr + rd);
    return 4 * (rd - wr);
  endfunction
endpackage

// File: rtl/wmf_ptrs.sv
module wmf_ptrs #(
  parameter int unsigned DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_req,
  input  logic                     rd_req,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [$clog2(DEPTH):0]   fill,
  output logic                     full,
  output logic                     empty,
  output logic                     wr_fire,
  output logic                     rd_fire,
  output logic                     wr_drop
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + AW'(1);
  endfunction

  always_comb begin
    if (wr_addr >= rd_addr) fill = CW'(wr_addr) - CW'(rd_addr);
    else                    fill = CW'(DEPTH) - CW'(rd_addr) + CW'(wr_addr);
  end

  assign empty   = (wr_addr == rd_addr);
  assign full    = (fill == CW'(DEPTH - 1));
  assign wr_fire = wr_req & ~full & ~clr;
  assign wr_drop = wr_req &  full & ~clr;
  assign rd_fire = rd_req & ~empty & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
    end else if (clr) begin
      wr_addr <= '0;
      rd_addr <= '0;
    end else begin
      if (wr_fire) wr_addr <= bump(wr_addr);
      if (rd_fire) rd_addr <= bump(rd_addr);
    end
  end

  // R3: capacity never exceeds DEPTH-1 words
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH - 1));
  // R3: a dropped write does not move the write address
  a_r3_drop_holds_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(wr_addr));
  // R11: clear returns both addresses to zero
  a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wr_addr == '0 && rd_addr == '0));
  // R9: equal addresses mean zero fill
  a_r9_empty_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (fill == '0));
endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_fire,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_req,
  input  logic                     rd_fire,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= wr_data;
  end

  // a refused read (empty ring or clear) returns zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= mem[rd_addr];
    else if (rd_req)  rd_data <= '0;
  end

  // R4: refused read yields zero data
  a_r4_refused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_fire) |=> (rd_data == '0));
endmodule

// File: rtl/wmf_flags.sv
module wmf_flags
  import wmf_pkg::*;
#(
  parameter int unsigned DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH):0]   fill,
  input  logic [$clog2(DEPTH)-1:0] af_thr,
  input  logic [$clog2(DEPTH)-1:0] ae_thr,
  input  logic                     full,
  input  logic                     empty,
  output logic [3:0]               status,
  output logic                     af_pulse,
  output logic                     ae_pulse
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic af_now, ae_now, af_q, ae_q;

  assign af_now = (fill >= CW'(af_thr));
  assign ae_now = (fill <= CW'(ae_thr));

  always_comb begin
    status            = '0;
    status[ST_FULL]   = full;
    status[ST_EMPTY]  = empty;
    status[ST_AFULL]  = af_now;
    status[ST_AEMPTY] = ae_now;
  end

  // previous levels, reset to the values seen with reset thresholds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q <= 1'b0;
      ae_q <= 1'b1;
    end else begin
      af_q <= af_now;
      ae_q <= ae_now;
    end
  end

  assign af_pulse = af_now & ~af_q;
  assign ae_pulse = ae_now & ~ae_q;

  // R10: each event pulse lasts a single cycle
  a_r10_af_single: assert property (@(posedge clk) disable iff (!rst_n)
    af_pulse |=> !af_pulse);
  a_r10_ae_single: assert property (@(posedge clk) disable iff (!rst_n)
    ae_pulse |=> !ae_pulse);
  // R12: top threshold flags almost-full only at real full
  a_r12_top_thr_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((af_thr == AW'(DEPTH - 1)) && status[ST_AFULL]) |-> full);
endmodule

// File: rtl/wm_word_fifo.sv
module wm_word_fifo
  import wmf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       wm_we,
  input  logic [31:0]                wm_wdata,
  output logic [31:0]                wm_q,
  output logic [3:0]                 status,
  output logic [31:0]                ptr_word,
  output logic [$clog2(DEPTH*4):0]   fill_bytes,
  output logic [$clog2(DEPTH*4):0]   free_bytes,
  output logic                       ae_pulse,
  output logic                       af_pulse,
  output logic                       ovf_pulse
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned BW = $clog2(DEPTH * 4) + 1;

  logic [AW-1:0] wr_addr, rd_addr, af_thr, ae_thr;
  logic [AW:0]   fill_w;
  logic          full_w, empty_w, wr_fire, rd_fire, wr_drop;

  wmf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_req(wr_en), .rd_req(rd_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .fill(fill_w),
    .full(full_w), .empty(empty_w),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .wr_drop(wr_drop)
  );

  wmf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_en), .rd_fire(rd_fire),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  wmf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .fill(fill_w), .af_thr(af_thr),
    .ae_thr(ae_thr), .full(full_w), .empty(empty_w),
    .status(status), .af_pulse(af_pulse), .ae_pulse(ae_pulse)
  );

  // threshold register: almost-full unused at reset, almost-empty at zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_thr <= AW'(DEPTH - 1);
      ae_thr <= '0;
    end else if (wm_we) begin
      af_thr <= wm_wdata[WM_AF_LSB +: AW];
      ae_thr <= wm_wdata[WM_AE_LSB +: AW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_pulse <= 1'b0;
    else        ovf_pulse <= wr_drop;
  end

  always_comb begin
    wm_q                       = '0;
    wm_q[WM_AF_LSB +: AW]      = af_thr;
    wm_q[WM_AE_LSB +: AW]      = ae_thr;
    ptr_word                   = '0;
    ptr_word[PW_WR_LSB +: AW+1] = {1'b0, wr_addr};
    ptr_word[PW_RD_LSB +: AW+1] = {1'b0, rd_addr};
  end

  assign fill_bytes = BW'(fill_bytes_f(32'(wr_addr), 32'(rd_addr), DEPTH));
  assign free_bytes = BW'(free_bytes_f(32'(wr_addr), 32'(rd_addr), DEPTH));

  // R6/R7: the two byte counts always add up to the full ring
  a_r7_counts_cover_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fill_bytes) + 32'(free_bytes)) == 32'(4 * DEPTH));
endmodule

// File: tb/sim_wm_word_fifo.sv
`timescale 1ns/1ps
module sim_wm_word_fifo;
  localparam int DEPTH = 512;

  logic        clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, wm_we = 1'b0;
  logic [31:0] wr_data = '0, wm_wdata = '0;
  logic [31:0] rd_data, wm_q, ptr_word;
  logic [3:0]  status;
  logic [11:0] fill_bytes, free_bytes;
  logic        ae_pulse, af_pulse, ovf_pulse;

  wm_word_fifo u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .wm_we(wm_we), .wm_wdata(wm_wdata),
    .wm_q(wm_q), .status(status), .ptr_word(ptr_word),
    .fill_bytes(fill_bytes), .free_bytes(free_bytes),
    .ae_pulse(ae_pulse), .af_pulse(af_pulse), .ovf_pulse(ovf_pulse)
  );

  always #4 clk = ~clk;  // 125 MHz

  int total = 0, bad = 0;
  bit done = 1'b0;
  // bench model
  int m_wr = 0, m_rd = 0, m_af = 511, m_ae = 0;
  int unsigned next_w = 0, next_r = 0;

  function automatic logic [31:0] pat(input int unsigned n);
    return 32'hC0DE_0000 ^ (n * 32'h0001_9E37);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int words_held();
    return (m_wr - m_rd + DEPTH) % DEPTH;
  endfunction

  task automatic chk_state(input string req);
    int w;
    logic [3:0] st;
    w = words_held();
    st[0] = (w == DEPTH - 1);
    st[1] = (w == 0);
    st[2] = (w >= m_af);
    st[3] = (w <= m_ae);
    chk(req, "ptr_word", ptr_word, (m_rd << 16) | m_wr);
    chk(req, "fill_bytes", 32'(fill_bytes), 4 * w);
    chk(req, "free_bytes", 32'(free_bytes), 4 * (DEPTH - w));
    chk(req, "status", 32'(status), 32'(st));
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      wr_data = pat(next_w);
      wr_en = 1'b1;
      tick();
      next_w++;
      m_wr = (m_wr + 1) % DEPTH;
    end
    wr_en = 1'b0;
  endtask

  task automatic pop(input string req);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    chk(req, "rd_data order", rd_data, pat(next_r));
    next_r++;
    m_rd = (m_rd + 1) % DEPTH;
  endtask

  task automatic t_reset();
    chk("R1", "status", 32'(status), 32'h0000_000A);
    chk("R1", "ptr_word", ptr_word, 32'h0);
    chk("R1", "fill_bytes", 32'(fill_bytes), 32'd0);
    chk("R1", "free_bytes", 32'(free_bytes), 32'd2048);
    chk("R1", "wm_q", wm_q, 32'h0000_01FF);
    chk("R1", "rd_data", rd_data, 32'h0);
    chk("R1", "pulses", {29'b0, ae_pulse, af_pulse, ovf_pulse}, 32'h0);
  endtask

  task automatic t_order();
    push(3);
    chk_state("R5");
    for (int i = 0; i < 3; i++) pop("R2");
    chk_state("R6");
  endtask

  task automatic t_empty_read();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    chk("R4", "rd_data on empty", rd_data, 32'h0);
    chk_state("R4");
  endtask

  task automatic t_watermark();
    wm_wdata = 32'hFFFF_FFFF; wm_we = 1'b1; tick(); wm_we = 1'b0;
    chk("R8", "wm_q masked", wm_q, 32'h01FF_01FF);
    m_af = 511; m_ae = 511;
    wm_wdata = (32'd2 << 16) | 32'd4; wm_we = 1'b1; tick(); wm_we = 1'b0;
    m_af = 4; m_ae = 2;
    chk("R8", "wm_q fields", wm_q, 32'h0002_0004);
    chk_state("R9");
    push(3);
    chk_state("R9");
    chk("R10", "af_pulse before level", 32'(af_pulse), 32'd0);
    push(1);
    chk_state("R9");
    chk("R10", "af_pulse on rise", 32'(af_pulse), 32'd1);
    tick();
    chk("R10", "af_pulse drops", 32'(af_pulse), 32'd0);
    pop("R2");
    chk("R10", "ae_pulse above level", 32'(ae_pulse), 32'd0);
    pop("R2");
    chk_state("R9");
    chk("R10", "ae_pulse on rise", 32'(ae_pulse), 32'd1);
    tick();
    chk("R10", "ae_pulse drops", 32'(ae_pulse), 32'd0);
  endtask

  task automatic t_full();
    wm_wdata = 32'h0000_01FF; wm_we = 1'b1; tick(); wm_we = 1'b0;
    m_af = 511; m_ae = 0;
    clr = 1'b1; tick(); clr = 1'b0;
    m_wr = 0; m_rd = 0; next_r = next_w;
    chk_state("R11");
    push(510);
    chk_state("R12");
    push(1);
    chk_state("R3");
    chk("R12", "almost full at real full", 32'(status[2]), 32'd1);
    wr_data = 32'hDEAD_BEEF; wr_en = 1'b1; tick(); wr_en = 1'b0;
    chk("R3", "ovf_pulse on dropped write", 32'(ovf_pulse), 32'd1);
    chk_state("R3");
    tick();
    chk("R3", "ovf_pulse drops", 32'(ovf_pulse), 32'd0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 10; i++) pop("R2");
    push(5);
    chk_state("R6");
    chk("R7", "free_bytes wrapped", 32'(free_bytes), 32'd24);
    chk("R6", "fill_bytes wrapped", 32'(fill_bytes), 32'd2024);
  endtask

  task automatic t_clear();
    push(5);
    chk_state("R3");
    clr = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wr_data = 32'h1234_5678;
    tick();
    clr = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    m_wr = 0; m_rd = 0; next_r = next_w;
    chk("R11", "no ovf on clear", 32'(ovf_pulse), 32'd0);
    chk_state("R11");
    push(2);
    pop("R11");
    chk_state("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_empty_read();
    t_watermark();
    t_full();
    t_wrap();
    t_clear();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule